// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a binary counter, four bits wide by default, whose register changes only on the rising clock edge. On each edge it does one of four things: it takes a parallel data word, it counts up by one, it counts down by one, or it keeps its value. A load request always wins. Counting needs both active-low count enables asserted. The direction input picks increment or decrement. The register wraps modulo 2^WIDTH in both directions.

An active-low terminal flag goes low when the register sits at its last value for the current direction: all ones going up, all zeros going down. The flag is gated only by the chained ("trickle") enable and never by the parallel enable. It is decoded combinationally, so it follows the direction and the chained enable in the same cycle. This lets wide counters be built from stages. Each stage's terminal flag drives the chained enable of the next stage. One shared parallel enable then stops or starts the whole chain without adding to the carry path.

A synchronous active-low reset clears the register to zero. It exists so that simulation starts from a known value.

Top module: `updn_cascade_ctr`

## Requirements
- R1: When rst_n is low at a rising edge, count_q becomes 0 after that edge, whatever the other inputs are.
- R2: When rst_n is high and load_n is low at a rising edge, count_q takes data_in after that edge. This happens whatever the levels of cnt_en_par_n, cnt_en_chain_n and dir_up.
- R3: When load_n is high, cnt_en_par_n and cnt_en_chain_n are both low, and dir_up is 1 at a rising edge, count_q increases by one.
- R4: When load_n is high, both count enables are low, and dir_up is 0 at a rising edge, count_q decreases by one.
- R5: When load_n is high and either count enable is high at a rising edge, count_q keeps its value.
- R6: Counting up from the all-ones value gives 0, and counting down from 0 gives the all-ones value (15 for WIDTH=4).
- R7: term_n is 0 exactly when cnt_en_chain_n is 0 and either dir_up is 1 with count_q all ones, or dir_up is 0 with count_q equal to 0. Otherwise term_n is 1.
- R8: term_n does not depend on cnt_en_par_n.
- R9: term_n follows changes on dir_up and cnt_en_chain_n within the same cycle, with no clock edge needed.
- R10: Two stages chained terminal flag to chained enable, with a shared parallel enable, count as one 8-bit up/down counter and carry correctly across the nibble boundary in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all register changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to zero |
| load_n | input | 1 | Active-low parallel load request (highest priority) |
| data_in | input | WIDTH | Value taken on a load |
| cnt_en_par_n | input | 1 | Active-low parallel count enable (does not gate term_n) |
| cnt_en_chain_n | input | 1 | Active-low chained count enable (gates term_n) |
| dir_up | input | 1 | Count direction: 1 up, 0 down |
| count_q | output | WIDTH | Current register value |
| term_n | output | 1 | Active-low terminal count flag |

## Verification
A wrong register value shows on count_q at the first sample after the edge that produced it. Because every later count is built on that value, the error persists until the next load or reset. A wrong terminal decode shows on term_n in the same cycle as the input or state that exposes it, before any edge. Across a cascade, a wrong decode shows one edge later as a wrong upper nibble. The wrap points and the enable-gating cases are therefore driven directly, and the result is sampled after each edge as well as just after each input change.

// File: rtl/ctr_pkg.sv
// Package: shared types for the cascadable up/down counter.
// Assumes: nothing beyond IEEE 1800-2017.
package ctr_pkg;
    // Operation applied to the register at the next rising edge
    typedef enum logic [1:0] {
        CTR_HOLD = 2'd0,
        CTR_LOAD = 2'd1,
        CTR_INC  = 2'd2,
        CTR_DEC  = 2'd3
    } ctr_op_e;
endpackage

// File: rtl/ctr_mode_sel.sv
// Module: ctr_mode_sel
// Chooses the register operation from the control inputs. Load wins over
// counting. Counting needs both active-low enables low. Otherwise the
// register holds.
// Assumes: inputs are stable around the rising clock edge.
module ctr_mode_sel
    import ctr_pkg::*;
(
    input  logic    load_n,
    input  logic    par_en_n,
    input  logic    chain_en_n,
    input  logic    dir_up,
    output ctr_op_e op
);
    // Priority decode of the operation
    always_comb begin
        if (!load_n)
            op = CTR_LOAD;
        else if (!par_en_n && !chain_en_n)
            op = dir_up ? CTR_INC : CTR_DEC;
        else
            op = CTR_HOLD;
    end
endmodule

// File: rtl/ctr_state_reg.sv
// Module: ctr_state_reg
// Holds the count and applies the selected operation on the rising edge.
// Arithmetic wraps modulo 2^WIDTH.
// Assumes: op is a valid ctr_op_e; rst_n is synchronous and active low.
module ctr_state_reg
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctr_op_e          op,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    logic [WIDTH-1:0] q_next;

    // Next-state selection from the decoded operation
    always_comb begin
        unique case (op)
            CTR_LOAD: q_next = load_val;
            CTR_INC:  q_next = q + STEP;
            CTR_DEC:  q_next = q - STEP;
            default:  q_next = q;
        endcase
    end

    // Count register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= q_next;
    end
endmodule

// File: rtl/ctr_term_decode.sv
// Module: ctr_term_decode
// Combinational active-low terminal flag: the last value for the current
// direction, gated only by the chained enable.
// Assumes: the parallel enable is deliberately not an input here.
module ctr_term_decode #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             dir_up,
    input  logic             chain_en_n,
    output logic             term_n
);
    logic at_top;
    logic at_bottom;

    // Edge-of-range detection and direction/enable gating
    always_comb begin
        at_top    = &q;
        at_bottom = ~|q;
        term_n    = ~(~chain_en_n & (dir_up ? at_top : at_bottom));
    end
endmodule

// File: rtl/updn_cascade_ctr.sv
// Module: updn_cascade_ctr
// Top of the cascadable synchronous up/down counter: mode select, count
// register and terminal decode. Assertions check the port-level behaviour.
// Assumes: one clock domain; rst_n is synchronous and active low.
module updn_cascade_ctr
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic             cnt_en_par_n,
    input  logic             cnt_en_chain_n,
    input  logic             dir_up,
    output logic [WIDTH-1:0] count_q,
    output logic             term_n
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    ctr_op_e op;

    ctr_mode_sel u_mode (
        .load_n     (load_n),
        .par_en_n   (cnt_en_par_n),
        .chain_en_n (cnt_en_chain_n),
        .dir_up     (dir_up),
        .op         (op)
    );

    ctr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (data_in),
        .q        (count_q)
    );

    ctr_term_decode #(.WIDTH(WIDTH)) u_term (
        .q          (count_q),
        .dir_up     (dir_up),
        .chain_en_n (cnt_en_chain_n),
        .term_n     (term_n)
    );

    // Reset clears the register (R1)
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> count_q == '0);

    // Load takes the data word whatever the enables are (R2)
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count_q == $past(data_in));

    // Increment by one (R3)
    assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_par_n && !cnt_en_chain_n && dir_up)
        |=> count_q == $past(count_q) + WIDTH'(1));

    // Decrement by one (R4)
    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_par_n && !cnt_en_chain_n && !dir_up)
        |=> count_q == $past(count_q) - WIDTH'(1));

    // Either enable high holds the value (R5)
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (cnt_en_par_n || cnt_en_chain_n)) |=> $stable(count_q));

    // Wrap at the top going up (R6)
    assert_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_par_n && !cnt_en_chain_n && dir_up && count_q == ALL_ONES)
        |=> count_q == '0);

    // Wrap at zero going down (R6)
    assert_wrap_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_par_n && !cnt_en_chain_n && !dir_up && count_q == '0)
        |=> count_q == ALL_ONES);

    // Flag is only low with the chained enable low (R7)
    assert_term_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !term_n |-> !cnt_en_chain_n);

    // Flag low going up implies all ones (R7)
    assert_term_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!term_n && dir_up) |-> count_q == ALL_ONES);

    // Flag low going down implies zero (R7)
    assert_term_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!term_n && !dir_up) |-> count_q == '0);

    // Flag unaffected by the parallel enable alone (R8)
    assert_term_par_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(count_q) && $stable(dir_up) && $stable(cnt_en_chain_n))
        |-> $stable(term_n));
endmodule

// File: tb/tb_updn_cascade_ctr.sv
// Two-stage chain used by the bench to build an 8-bit counter (R10).
module tb_ctr_chain #(
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_n,
    input  logic [4*STAGES-1:0]   data_in,
    input  logic                  par_n,
    input  logic                  dir_up,
    output logic [4*STAGES-1:0]   count_q
);
    logic [STAGES:0] link;
    assign link[0] = 1'b0;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        updn_cascade_ctr #(.WIDTH(4)) u_stage (
            .clk            (clk),
            .rst_n          (rst_n),
            .load_n         (load_n),
            .data_in        (data_in[4*g +: 4]),
            .cnt_en_par_n   (par_n),
            .cnt_en_chain_n (link[g]),
            .dir_up         (dir_up),
            .count_q        (count_q[4*g +: 4]),
            .term_n         (link[g+1])
        );
    end
endmodule

// Scoreboard bench for updn_cascade_ctr.
module tb_updn_cascade_ctr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] data_in = '0;
    logic       par_n = 1'b1;
    logic       chain_n = 1'b1;
    logic       dir_up = 1'b1;
    logic [7:0] c_data = '0;
    logic [3:0] count_q;
    logic       term_n;
    logic [7:0] c_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0] cnt;
        logic       term;
        logic [7:0] casc;
        string      tag;
    } exp_t;

    exp_t sb[$];

    logic [3:0] m_q;
    logic [7:0] m_c;
    bit         m_ok = 1'b0;

    always #5 clk = ~clk;

    updn_cascade_ctr #(.WIDTH(4)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_n         (load_n),
        .data_in        (data_in),
        .cnt_en_par_n   (par_n),
        .cnt_en_chain_n (chain_n),
        .dir_up         (dir_up),
        .count_q        (count_q),
        .term_n         (term_n)
    );

    tb_ctr_chain #(.STAGES(2)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_n  (load_n),
        .data_in (c_data),
        .par_n   (par_n),
        .dir_up  (dir_up),
        .count_q (c_count)
    );

    function automatic logic exp_term(logic [3:0] m, logic c, logic u);
        return !(!c && (u ? (m == 4'hF) : (m == 4'h0)));
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of stimulus, predict, push the expectation
    task automatic step(logic r, logic l, logic [3:0] d, logic p, logic c,
                        logic u, logic [7:0] cd, string tag);
        @(negedge clk);
        rst_n = r; load_n = l; data_in = d; par_n = p; chain_n = c;
        dir_up = u; c_data = cd;
        #1;
        // R9: flag follows the new inputs before any edge
        if (m_ok) check({tag, " R9 immediate flag"}, {7'd0, term_n}, {7'd0, exp_term(m_q, c, u)});
        if (!r) begin
            m_q = '0; m_c = '0;
        end else if (!l) begin
            m_q = d; m_c = cd;
        end else begin
            if (!p && !c) m_q = u ? m_q + 4'd1 : m_q - 4'd1;
            if (!p)       m_c = u ? m_c + 8'd1 : m_c - 8'd1;
        end
        m_ok = 1'b1;
        sb.push_back('{cnt: m_q, term: exp_term(m_q, c, u), casc: m_c, tag: tag});
    endtask

    // Monitor: after each edge, pop and compare
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " count"}, {4'd0, count_q}, {4'd0, e.cnt});
                check({e.tag, " R7 flag"}, {7'd0, term_n}, {7'd0, e.term});
                check({e.tag, " R10 chain"}, c_count, e.casc);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, all requirements unconfirmed");
            finish_run();
        end
    end

    initial begin
        step(0, 0, 4'h9, 0, 0, 1, 8'h55, "R1 reset wins");
        step(1, 0, 4'hA, 1, 1, 1, 8'hA0, "R2 load idle");
        step(1, 0, 4'h3, 0, 0, 0, 8'h30, "R2 load over count");
        step(1, 1, 4'h0, 0, 0, 1, 8'h00, "R3 up");
        step(1, 1, 4'h0, 0, 0, 1, 8'h00, "R3 up");
        step(1, 1, 4'h0, 0, 0, 0, 8'h00, "R4 down");
        step(1, 1, 4'h0, 1, 0, 1, 8'h00, "R5 hold par high");
        step(1, 1, 4'h0, 0, 1, 1, 8'h00, "R5 hold chain high");
        step(1, 0, 4'hE, 1, 1, 1, 8'hFD, "R2 load E");
        step(1, 1, 4'h0, 0, 0, 1, 8'h00, "R3 up to top");
        step(1, 1, 4'h0, 1, 0, 1, 8'h00, "R8 par high flag low");
        step(1, 1, 4'h0, 1, 1, 1, 8'h00, "R7 chain high flag high");
        step(1, 1, 4'h0, 0, 0, 1, 8'h00, "R6 wrap up");
        step(1, 1, 4'h0, 0, 0, 0, 8'h00, "R6 wrap down");
        step(1, 1, 4'h0, 0, 0, 0, 8'h00, "R4 down");
        step(1, 0, 4'h1, 1, 1, 0, 8'h0E, "R2 load 1");
        step(1, 1, 4'h0, 0, 0, 0, 8'h00, "R4 down to zero");
        step(1, 1, 4'h0, 1, 0, 0, 8'h00, "R8 hold at zero flag low");
        step(1, 1, 4'h0, 1, 0, 1, 8'h00, "R9 dir flip");
        step(1, 1, 4'h0, 1, 1, 0, 8'h00, "R9 chain flip");
        for (int i = 0; i < 20; i++)
            step(1, 1, 4'h0, 0, 0, 1, 8'h00, "R10 chain up");
        for (int i = 0; i < 40; i++)
            step(1, 1, 4'h0, 0, 0, 0, 8'h00, "R10 chain down");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule